// File: doc/BRIEF.md
# SATA Device-Side DMA Command Responder

This block plays the drive end of a reduced SATA command exchange. Frames arrive on an inbound stream that carries a frame type code, start and end markers and one 32-bit dword per beat. Host-to-device register frames carry a command byte. The block answers three commands: DMA write, DMA read and identify-device by DMA. It answers on an outbound stream with the same shape. Payload from the host is kept in a small dword memory inside the block, and read commands are served from that memory.

Responses go out in a fixed order for each command. A write is first acknowledged with a DMA-activate frame. Its status frame is sent only when the declared number of payload dwords has arrived, which may take several data frames. A read or an identify produces one data frame and then a status frame. While a response is pending or being sent, the inbound stream is held off. Responses therefore never overlap, and memory contents cannot change under a frame that is in flight.

Top module: `sata_dma_responder`

## Requirements
- R1: During and right after reset, `out_valid` is low and `in_ready` is high.
- R2: A register frame (type 4'b0001) of at least three dwords, where dword 0 bits [7:0] = 8'h35, dword 1 gives the start address and dword 2 bits [15:0] give the dword count, opens a write. The block answers with one DMA-activate frame: type 4'b0100, a single dword of zero with sop and eop both set.
- R3: While a write is open, every data frame (type 4'b1000) has its first dword discarded. The dwords after it are stored at consecutive addresses, continuing from where the previous frame of the same write stopped.
- R4: A status frame is sent when, at the end of a data frame, the total payload received for the open write equals the count. The status frame is type 4'b0010, a single dword 32'h0000_0050 with sop and eop set. The write then closes. A frame that leaves the total short produces no output.
- R5: A register frame with command 8'h25 produces one data frame and then a status frame. The data frame is type 4'b1000: a zero header dword with sop, then `count` dwords read from memory starting at the address, with eop on the last.
- R6: A register frame with command 8'hEE produces a data frame and then a status frame. The data frame has a zero header and 256 payload dwords holding 0 to 255 in order. The count field is not used.
- R7: A write or read whose count is 0 or above 2048 gets no response and opens no write. A count of exactly 2048 is served.
- R8: Frames of any other type, register frames with any other command byte, and register frames shorter than three dwords are consumed with no response.
- R9: A data frame that arrives while no write is open is consumed and leaves memory unchanged.
- R10: Each output frame carries sop only on its first dword and eop only on its last. While `out_ready` is low, the output beat is held unchanged. No dword is dropped or repeated.
- R11: A new output frame starts only after the previous frame's eop has been accepted. `in_ready` stays low while any response is pending or being sent.
- R12: Addresses are taken modulo the memory depth (1024 dwords by default). Payload and read data wrap from the top address to address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inbound beat valid |
| in_ready | output | 1 | Inbound beat accepted when high together with valid |
| in_type | input | 4 | Inbound frame type code, sampled on the sop beat |
| in_sop | input | 1 | First dword of an inbound frame |
| in_eop | input | 1 | Last dword of an inbound frame |
| in_data | input | 32 | Inbound dword |
| out_valid | output | 1 | Outbound beat valid |
| out_ready | input | 1 | Downstream accepts the outbound beat |
| out_type | output | 4 | Outbound frame type code |
| out_sop | output | 1 | First dword of an outbound frame |
| out_eop | output | 1 | Last dword of an outbound frame |
| out_data | output | 32 | Outbound dword |

## Verification
The bench aims at four cases. The first is a write whose payload is split over several data frames, including a partial total that must stay silent. A design that compares per frame instead of per write would answer too early or never. The second is the count boundaries 0, 2048 and 2049: an off-by-one limit either drops the largest legal transfer or answers an illegal one. The third is transfers that cross the top of memory, where a bad wrap shows up as wrong read-back data. The fourth is random backpressure on the outbound stream with bursts of inbound traffic. A framer that advances without a handshake drops or duplicates dwords, and one that lets the input run during a response breaks the order of frames.

// File: rtl/sata_resp_pkg.sv
package sata_resp_pkg;

   localparam int TYPE_W = 4;
   typedef logic [TYPE_W-1:0] fis_type_t;

   // one-hot frame type codes
   localparam fis_type_t FT_REG_H2D = 4'b0001;
   localparam fis_type_t FT_REG_D2H = 4'b0010;
   localparam fis_type_t FT_DMA_ACT = 4'b0100;
   localparam fis_type_t FT_DATA    = 4'b1000;

   localparam logic [7:0]  CMD_WR_DMA  = 8'h35;
   localparam logic [7:0]  CMD_RD_DMA  = 8'h25;
   localparam logic [7:0]  CMD_ID_DMA  = 8'hEE;
   localparam logic [31:0] GOOD_STATUS = 32'h0000_0050;

   typedef enum logic [1:0] {
      EV_ACT,
      EV_READ,
      EV_IDENT,
      EV_STAT
   } evt_kind_t;

endpackage

// File: rtl/rsp_dword_mem.sv
module rsp_dword_mem #(
   parameter int DEPTH = 1024,
   parameter int DW    = 32,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   // asynchronous read keeps the framer free of a prefetch stage
   assign rdata = store[raddr];

endmodule

// File: rtl/rsp_rx_parser.sv
module rsp_rx_parser
   import sata_resp_pkg::*;
#(
   parameter int AW       = 10,
   parameter int LW       = 12,
   parameter int MAX_XFER = 2048,
   parameter int ID_WORDS = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            hold,
   input  logic            in_valid,
   output logic            in_ready,
   input  fis_type_t       in_type,
   input  logic            in_sop,
   input  logic            in_eop,
   input  logic [31:0]     in_data,
   output logic            mem_we,
   output logic [AW-1:0]   mem_waddr,
   output logic [31:0]     mem_wdata,
   output logic            evt_valid,
   output evt_kind_t       evt_kind,
   output logic [AW-1:0]   evt_addr,
   output logic [LW-1:0]   evt_len
);

   localparam int CW = 16;

   logic            take;
   logic [1:0]      widx;
   logic [1:0]      idx_now;
   fis_type_t       ftype;
   fis_type_t       cur_type;
   logic [7:0]      cmd_q;
   logic [AW-1:0]   lba_q;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   cnt_now;
   logic            cnt_ok;
   logic            reg_full;
   logic            is_reg;
   logic            is_data;
   logic            payload;
   logic            wr_open;
   logic [AW-1:0]   wr_base;
   logic [CW-1:0]   wr_len;
   logic [CW-1:0]   wr_cnt;
   logic [CW-1:0]   wr_cnt_nx;

   assign in_ready  = !hold && !evt_valid;
   assign take      = in_valid && in_ready;
   assign idx_now   = in_sop ? 2'd0 : widx;
   assign cur_type  = in_sop ? in_type : ftype;
   assign is_reg    = (cur_type == FT_REG_H2D);
   assign is_data   = (cur_type == FT_DATA);
   assign cnt_now   = (idx_now == 2'd2) ? in_data[CW-1:0] : cnt_q;
   assign cnt_ok    = (cnt_now != '0) && (cnt_now <= CW'(MAX_XFER));
   assign reg_full  = (idx_now >= 2'd2);

   // payload beats: data frame, past its header dword, write open
   assign payload   = take && is_data && (idx_now != 2'd0) && wr_open;
   assign wr_cnt_nx = wr_cnt + CW'(payload);
   assign mem_we    = payload;
   assign mem_waddr = wr_base + AW'(wr_cnt);
   assign mem_wdata = in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         widx      <= '0;
         ftype     <= '0;
         cmd_q     <= '0;
         lba_q     <= '0;
         cnt_q     <= '0;
         wr_open   <= 1'b0;
         wr_base   <= '0;
         wr_len    <= '0;
         wr_cnt    <= '0;
         evt_valid <= 1'b0;
         evt_kind  <= EV_ACT;
         evt_addr  <= '0;
         evt_len   <= '0;
      end else begin
         evt_valid <= 1'b0;
         if (take) begin
            ftype <= cur_type;
            if (in_eop)                widx <= 2'd0;
            else if (idx_now != 2'd3)  widx <= idx_now + 2'd1;
            else                       widx <= 2'd3;

            case (idx_now)
               2'd0:    cmd_q <= in_data[7:0];
               2'd1:    lba_q <= in_data[AW-1:0];
               2'd2:    cnt_q <= in_data[CW-1:0];
               default: ;
            endcase

            if (payload) wr_cnt <= wr_cnt_nx;

            if (in_eop && is_reg && reg_full) begin
               if (cmd_q == CMD_WR_DMA && cnt_ok) begin
                  evt_valid <= 1'b1;
                  evt_kind  <= EV_ACT;
                  wr_open   <= 1'b1;
                  wr_base   <= lba_q;
                  wr_len    <= cnt_now;
                  wr_cnt    <= '0;
               end else if (cmd_q == CMD_RD_DMA && cnt_ok) begin
                  evt_valid <= 1'b1;
                  evt_kind  <= EV_READ;
                  evt_addr  <= lba_q;
                  evt_len   <= LW'(cnt_now);
               end else if (cmd_q == CMD_ID_DMA) begin
                  evt_valid <= 1'b1;
                  evt_kind  <= EV_IDENT;
                  evt_addr  <= '0;
                  evt_len   <= LW'(ID_WORDS);
               end
            end

            if (in_eop && is_data && wr_open && (wr_cnt_nx == wr_len)) begin
               evt_valid <= 1'b1;
               evt_kind  <= EV_STAT;
               wr_open   <= 1'b0;
            end
         end
      end
   end

   // R11: an event is a one-cycle pulse; the inbound side stalls behind it
   a_r11_evt_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |=> !evt_valid);

endmodule

// File: rtl/rsp_tx_framer.sv
module rsp_tx_framer
   import sata_resp_pkg::*;
#(
   parameter int AW = 10,
   parameter int LW = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            evt_valid,
   input  evt_kind_t       evt_kind,
   input  logic [AW-1:0]   evt_addr,
   input  logic [LW-1:0]   evt_len,
   output logic            busy,
   output logic [AW-1:0]   mem_raddr,
   input  logic [31:0]     mem_rdata,
   output logic            out_valid,
   input  logic            out_ready,
   output fis_type_t       out_type,
   output logic            out_sop,
   output logic            out_eop,
   output logic [31:0]     out_data
);

   typedef enum logic [2:0] {
      F_IDLE,
      F_ACT,
      F_HDR,
      F_PAY,
      F_STAT
   } fstate_t;

   fstate_t        st;
   logic [AW-1:0]  base;
   logic [LW-1:0]  len;
   logic [LW-1:0]  idx;
   logic           ident;
   logic           last;

   assign last      = (idx == len - LW'(1));
   assign mem_raddr = base + AW'(idx);
   assign busy      = (st != F_IDLE);

   always_comb begin
      out_valid = 1'b1;
      out_type  = FT_DATA;
      out_sop   = 1'b0;
      out_eop   = 1'b0;
      out_data  = '0;
      unique case (st)
         F_IDLE: out_valid = 1'b0;
         F_ACT: begin
            out_type = FT_DMA_ACT;
            out_sop  = 1'b1;
            out_eop  = 1'b1;
         end
         F_HDR: out_sop = 1'b1;
         F_PAY: begin
            out_eop  = last;
            out_data = ident ? 32'(idx) : mem_rdata;
         end
         F_STAT: begin
            out_type = FT_REG_D2H;
            out_sop  = 1'b1;
            out_eop  = 1'b1;
            out_data = GOOD_STATUS;
         end
         default: out_valid = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= F_IDLE;
         base  <= '0;
         len   <= '0;
         idx   <= '0;
         ident <= 1'b0;
      end else begin
         case (st)
            F_IDLE: if (evt_valid) begin
               base  <= evt_addr;
               len   <= evt_len;
               idx   <= '0;
               ident <= (evt_kind == EV_IDENT);
               case (evt_kind)
                  EV_ACT:  st <= F_ACT;
                  EV_STAT: st <= F_STAT;
                  default: st <= F_HDR;
               endcase
            end
            F_ACT, F_STAT: if (out_ready) st <= F_IDLE;
            F_HDR:         if (out_ready) st <= F_PAY;
            F_PAY: if (out_ready) begin
               idx <= idx + LW'(1);
               if (last) st <= F_STAT;
            end
            default: st <= F_IDLE;
         endcase
      end
   end

   // R10: a stalled beat must not change
   a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_type)
                                     && $stable(out_sop) && $stable(out_eop)));

   // R10: type code on the wire is one-hot
   a_r10_type_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> ($countones(out_type) == 1));

   // R4: a finished outbound data frame is followed at once by status
   a_r4_status_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_eop && out_type == FT_DATA)
         |=> (out_valid && out_type == FT_REG_D2H && out_sop && out_eop));

endmodule

// File: rtl/sata_dma_responder.sv
module sata_dma_responder
   import sata_resp_pkg::*;
#(
   parameter int MEM_DEPTH = 1024,
   parameter int MAX_XFER  = 2048,
   parameter int ID_WORDS  = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        in_valid,
   output logic        in_ready,
   input  logic [3:0]  in_type,
   input  logic        in_sop,
   input  logic        in_eop,
   input  logic [31:0] in_data,
   output logic        out_valid,
   input  logic        out_ready,
   output logic [3:0]  out_type,
   output logic        out_sop,
   output logic        out_eop,
   output logic [31:0] out_data
);

   localparam int AW = $clog2(MEM_DEPTH);
   localparam int LW = $clog2(MAX_XFER + 1);

   generate
      if (MEM_DEPTH < 2 || (MEM_DEPTH & (MEM_DEPTH - 1)) != 0) begin : g_bad_depth
         $error("MEM_DEPTH must be a power of two of at least 2");
      end
      if (MAX_XFER < 1 || MAX_XFER > 65535) begin : g_bad_xfer
         $error("MAX_XFER must lie in 1..65535 to fit the count field");
      end
      if (ID_WORDS < 1 || ID_WORDS > MAX_XFER) begin : g_bad_ident
         $error("ID_WORDS must lie in 1..MAX_XFER");
      end
      if (AW > 16) begin : g_bad_aw
         $error("MEM_DEPTH exceeds the 16-bit progress counter");
      end
   endgenerate

   logic            busy;
   logic            evt_valid;
   evt_kind_t       evt_kind;
   logic [AW-1:0]   evt_addr;
   logic [LW-1:0]   evt_len;
   logic            mem_we;
   logic [AW-1:0]   mem_waddr;
   logic [31:0]     mem_wdata;
   logic [AW-1:0]   mem_raddr;
   logic [31:0]     mem_rdata;
   fis_type_t       tx_type;

   rsp_rx_parser #(
      .AW(AW), .LW(LW), .MAX_XFER(MAX_XFER), .ID_WORDS(ID_WORDS)
   ) u_parser (
      .clk(clk), .rst_n(rst_n), .hold(busy),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .evt_valid(evt_valid), .evt_kind(evt_kind),
      .evt_addr(evt_addr), .evt_len(evt_len)
   );

   rsp_dword_mem #(
      .DEPTH(MEM_DEPTH), .DW(32), .AW(AW)
   ) u_mem (
      .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
      .raddr(mem_raddr), .rdata(mem_rdata)
   );

   rsp_tx_framer #(
      .AW(AW), .LW(LW)
   ) u_framer (
      .clk(clk), .rst_n(rst_n),
      .evt_valid(evt_valid), .evt_kind(evt_kind),
      .evt_addr(evt_addr), .evt_len(evt_len), .busy(busy),
      .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(tx_type),
      .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
   );

   assign out_type = tx_type;

   // R11: inbound stream is stalled while a response is in flight
   a_r11_no_input_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready);

   // R11: the parser only raises a response request when the framer is free
   a_r11_evt_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid |-> !busy);

endmodule

// File: tb/sata_dma_responder_tb.sv
`timescale 1ns/1ps
module sata_dma_responder_tb;

   localparam int DEPTH = 1024;
   localparam int MAXX  = 2048;
   localparam int QN    = 16384;
   localparam logic [3:0] T_H2D = 4'b0001, T_D2H = 4'b0010, T_ACT = 4'b0100, T_DATA = 4'b1000;
   localparam logic [31:0] GOOD = 32'h0000_0050;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_type = '0;
   logic        in_sop = 1'b0;
   logic        in_eop = 1'b0;
   logic [31:0] in_data = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [3:0]  out_type;
   logic        out_sop;
   logic        out_eop;
   logic [31:0] out_data;

   sata_dma_responder u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
      .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data)
   );

   always #10 clk = ~clk;

   logic [31:0] mmem   [DEPTH];
   logic [3:0]  q_type [QN];
   logic        q_sop  [QN];
   logic        q_eop  [QN];
   logic [31:0] q_data [QN];
   int    wp = 0, rp = 0, checks = 0, errors = 0, cyc = 0;
   string tag = "R1";
   bit    m_open = 0;
   int    m_base = 0, m_len = 0, m_cnt = 0;
   bit    ready_all = 0;
   bit    gaps = 0;
   logic  rdy_pick;

   function automatic void push(logic [3:0] t, logic s, logic e, logic [31:0] d);
      q_type[wp % QN] = t; q_sop[wp % QN] = s; q_eop[wp % QN] = e; q_data[wp % QN] = d;
      wp++;
   endfunction

   function automatic void exp_data_frame(int addr, int n, bit ident);
      push(T_DATA, 1'b1, 1'b0, 32'h0);
      for (int i = 0; i < n; i++)
         push(T_DATA, 1'b0, i == n - 1, ident ? 32'(i) : mmem[(addr + i) % DEPTH]);
      push(T_D2H, 1'b1, 1'b1, GOOD);
   endfunction

   // outbound checker: ready chosen at negedge, transfer happens at next posedge
   always @(negedge clk) begin
      if (rst_n) begin
         rdy_pick = ready_all ? 1'b1 : (($urandom % 4) != 0);
         out_ready = rdy_pick;
         if (out_valid && in_ready) begin
            checks++; errors++;
            $display("FAIL R11: in_ready actual=1 expected=0 while response active");
         end
         if (out_valid && rdy_pick) begin
            checks++;
            if (rp == wp) begin
               errors++;
               $display("FAIL %s: unexpected beat actual type=%h data=%h expected none", tag, out_type, out_data);
            end else begin
               if (out_type !== q_type[rp % QN] || out_sop !== q_sop[rp % QN] ||
                   out_eop !== q_eop[rp % QN] || out_data !== q_data[rp % QN]) begin
                  errors++;
                  $display("FAIL %s: beat %0d actual type=%h sop=%b eop=%b data=%h expected type=%h sop=%b eop=%b data=%h",
                           tag, rp, out_type, out_sop, out_eop, out_data,
                           q_type[rp % QN], q_sop[rp % QN], q_eop[rp % QN], q_data[rp % QN]);
               end
               rp++;
            end
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: cycles actual=%0d expected<=150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic send_word(logic [3:0] t, logic s, logic e, logic [31:0] d);
      if (gaps && ($urandom % 4) == 0) begin
         in_valid = 1'b0;
         repeat (1 + $urandom % 2) @(negedge clk);
      end
      in_valid = 1'b1; in_type = t; in_sop = s; in_eop = e; in_data = d;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_reg(logic [7:0] cmd, int addr, int cnt, int nw);
      bit ok;
      ok = (cnt >= 1) && (cnt <= MAXX);
      if (nw >= 3) begin
         if (cmd == 8'h35 && ok) begin
            push(T_ACT, 1'b1, 1'b1, 32'h0);
            m_open = 1; m_base = addr % DEPTH; m_len = cnt; m_cnt = 0;
         end else if (cmd == 8'h25 && ok) exp_data_frame(addr % DEPTH, cnt, 1'b0);
         else if (cmd == 8'hEE)            exp_data_frame(0, 256, 1'b1);
      end
      for (int i = 0; i < nw; i++) begin
         logic [31:0] w;
         w = (i == 0) ? {24'h0, cmd} : (i == 1) ? 32'(addr) : (i == 2) ? {16'h0, 16'(cnt)} : $urandom;
         send_word(T_H2D, i == 0, i == nw - 1, w);
      end
   endtask

   task automatic send_data(int n);
      logic [31:0] w;
      if (m_open && (m_cnt + n == m_len)) push(T_D2H, 1'b1, 1'b1, GOOD);
      send_word(T_DATA, 1'b1, n == 0, $urandom);
      for (int i = 0; i < n; i++) begin
         w = $urandom;
         if (m_open) begin
            mmem[(m_base + m_cnt) % DEPTH] = w;
            m_cnt++;
         end
         send_word(T_DATA, 1'b0, i == n - 1, w);
      end
      if (m_open && m_cnt == m_len) m_open = 0;
   endtask

   task automatic send_junk(logic [3:0] t, int nw);
      for (int i = 0; i < nw; i++) send_word(t, i == 0, i == nw - 1, $urandom);
   endtask

   task automatic wait_drain(string t);
      int n;
      n = 0;
      while ((rp != wp || out_valid) && n < 8000) begin
         @(negedge clk);
         n++;
      end
      repeat (6) @(negedge clk);
      checks++;
      if (rp != wp || out_valid) begin
         errors++;
         $display("FAIL %s: drained beats actual=%0d expected=%0d", t, rp, wp);
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: in reset actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
         errors++;
         $display("FAIL R1: after reset actual valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
      end

      // R2 / R3 / R4: fill the whole memory with one write
      tag = "R2"; send_reg(8'h35, 0, DEPTH, 3); wait_drain("R2");
      tag = "R3"; send_data(DEPTH); wait_drain("R3");

      tag = "R5"; send_reg(8'h25, 16, 16, 3); wait_drain("R5");
      tag = "R6"; send_reg(8'hEE, 7, 0, 3); wait_drain("R6");

      // R4: short payload stays silent, completion answers
      tag = "R4"; send_reg(8'h35, 100, 8, 3); wait_drain("R4");
      send_data(5); wait_drain("R4");
      send_data(3); wait_drain("R4");
      send_reg(8'h25, 100, 8, 3); wait_drain("R4");

      // R12: wrap at the top of memory and address modulo depth
      tag = "R12"; send_reg(8'h35, 1020, 8, 3); send_data(8); wait_drain("R12");
      send_reg(8'h25, 1020, 8, 3); wait_drain("R12");
      send_reg(8'h25, 2044, 4, 3); wait_drain("R12");

      // R7: count limits
      tag = "R7"; send_reg(8'h35, 5, 0, 3); wait_drain("R7");
      send_reg(8'h35, 5, MAXX + 1, 3); wait_drain("R7");
      send_reg(8'h25, 5, MAXX + 1, 3); wait_drain("R7");
      send_reg(8'h25, 500, MAXX, 3); wait_drain("R7");

      // R9: data with no open write, then read back the region
      tag = "R9"; send_data(4); wait_drain("R9");
      send_reg(8'h25, 0, 8, 3); wait_drain("R9");

      // R8: other types, unknown command, short and long register frames
      tag = "R8"; send_junk(T_D2H, 3); wait_drain("R8");
      send_junk(4'b0000, 2); wait_drain("R8");
      send_reg(8'h99, 3, 4, 3); wait_drain("R8");
      send_reg(8'h35, 3, 4, 2); wait_drain("R8");
      send_reg(8'h25, 40, 6, 5); wait_drain("R8");

      // R10 / R11: random traffic with backpressure and inbound gaps
      tag = "R10"; gaps = 1;
      for (int it = 0; it < 80; it++) begin
         int k, len, rem, ch;
         k = $urandom % 10;
         ready_all = (($urandom % 5) == 0);
         if (k <= 3) begin
            len = 1 + $urandom % 48;
            send_reg(8'h35, $urandom % 4096, len, 3);
            rem = len;
            while (rem > 0) begin
               ch = 1 + $urandom % rem;
               send_data(ch);
               rem -= ch;
            end
         end else if (k <= 6 || (k == 7 && ($urandom % 3) != 0)) begin
            send_reg(8'h25, $urandom % 4096, 1 + $urandom % 64, 3);
         end else if (k == 7) begin
            send_reg(8'hEE, 0, 1, 3);
         end else if (k == 8) begin
            send_junk(T_ACT, 1 + $urandom % 4);
         end else begin
            send_reg(8'h42, $urandom % 4096, 1 + $urandom % 8, 3);
         end
         if (($urandom % 2) == 0) wait_drain("R10");
      end
      wait_drain("R11");
      ready_all = 0;

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule